// File: doc/BRIEF.md
# Seconds-Tick Watchdog With Status-Read Stop

This block is a byte-wide countdown watchdog for a real-time-clock style peripheral. Software picks a tick source in a configuration register and writes a reload count into a value register. Each write of that register reloads the countdown, so the same write both starts the timer and kicks it. A value of zero means the timer is stopped. When a running count reaches zero, the block raises a timeout flag in the shared status register. If reset generation is enabled, it also drives an active-low reset pulse of fixed length.

The block models one known side effect on purpose. Any read of the shared status register forces the count to zero and so silently stops the watchdog. Software that reads status must therefore reload the value register afterwards.

The oscillator and the serial bus sit outside the block. The oscillator appears as two one-cycle tick-enable inputs: a fast tick and a one-second tick. The bus appears as single-cycle read and write strobes with an address, write data and combinational read data.

Top module: `sec_watchdog`

## Requirements
- R1: After reset, the value register reads 0x00, the configuration register reads 0x00, the status register reads 0x00, `wd_flag` is 0 and `wd_rst_n` is 1.
- R2: Writing a nonzero count to the value register (address 2) starts the countdown. While configuration bit 7 is set, the count drops by one on each selected tick. A read of address 2 returns the remaining count, which is nonzero while the timer runs.
- R3: Writing the value register while the timer runs reloads the count from the new value.
- R4: When the count steps from 1 to 0, the timeout flag (status register, address 0, bit 6) is set. The count then stays at 0 until software writes a new value.
- R5: A timeout while configuration bit 6 is set drives `wd_rst_n` low for exactly RST_CYCLES clocks, starting the cycle after the expiring tick. With bit 6 clear, the flag still sets and `wd_rst_n` stays high.
- R6: Any read of the status register sets the count to 0. Later ticks then have no effect and no timeout follows.
- R7: Writing the status register with bit 6 equal to 0 clears the flag, and writing it with bit 6 equal to 1 leaves the flag unchanged. A timeout in the same cycle as a clearing write leaves the flag set.
- R8: Writing 0 to the value register stops the timer. Ticks then neither change the count nor set the flag.
- R9: Configuration bits 1:0 select the tick: 00 is every fast tick, 01 is every TICK_DIV_FAST-th fast tick, 10 is every one-second tick, and 11 is every TICK_DIV_SLOW-th one-second tick. The source that is not selected has no effect. The dividers restart on each value write.
- R10: With configuration bit 7 clear, the count holds its value on ticks.
- R11: The configuration register (address 1) reads back bits 7, 6 and 1:0 as written, with bits 5:2 reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_fast | input | 1 | One-cycle enable from the fast timer source |
| tick_sec | input | 1 | One-cycle enable once per second |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address: 0 status, 1 configuration, 2 value |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| wd_flag | output | 1 | Timeout flag, mirrors status bit 6 |
| wd_rst_n | output | 1 | Active-low timeout reset pulse |

## Verification
The bench targets the edges of the countdown. It checks the exact cycle the reset pulse starts and the cycle it ends, and a design off by one there would give a pulse one clock short or long. It checks that the count parks at zero instead of wrapping to 255, and that a status read mid-count stops the timer instead of only returning the flag. It checks that a timeout racing a flag-clear write wins, that an unselected tick source or a stopped timer leaves the count alone, and that each divided mode expires on exactly the N-th tick and not one earlier.

// File: rtl/sec_wdt_pkg.sv
// Package: shared register addresses, bit positions and types for the
// seconds-tick watchdog. Assumes an 8-bit register file with 2-bit addressing.
package sec_wdt_pkg;
    localparam int REG_DW = 8;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADDR_STATUS = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_CFG    = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_VALUE  = 2'd2;

    localparam int FLAG_BIT      = 6;
    localparam int CFG_RUN_BIT   = 7;
    localparam int CFG_RSTEN_BIT = 6;

    typedef enum logic [1:0] {
        SRC_FAST     = 2'b00,
        SRC_FAST_DIV = 2'b01,
        SRC_SEC      = 2'b10,
        SRC_SEC_DIV  = 2'b11
    } tick_src_e;

    typedef struct packed {
        logic      run;
        logic      rst_en;
        tick_src_e src;
    } wdt_cfg_t;
endpackage

// File: rtl/sec_wdt_tick_sel.sv
// Tick selector: builds divided versions of both raw tick inputs and picks
// the one named by the configured source. Assumes each raw tick is a
// one-cycle enable; dividers restart when 'restart' is high.
module sec_wdt_tick_sel
    import sec_wdt_pkg::*;
#(
    parameter int DIV_FAST = 4,
    parameter int DIV_SLOW = 60
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      restart,
    input  logic      tick_fast,
    input  logic      tick_sec,
    input  tick_src_e src,
    output logic      tick_out
);
    localparam int NSRC = 2;

    logic [NSRC-1:0] raw_tick;
    logic [NSRC-1:0] div_tick;

    assign raw_tick = {tick_sec, tick_fast};

    for (genvar g = 0; g < NSRC; g++) begin : g_div
        localparam int DIV = (g == 0) ? DIV_FAST : DIV_SLOW;
        localparam int CW  = ($clog2(DIV) > 0) ? $clog2(DIV) : 1;

        logic [CW-1:0] phase;
        logic          at_last;

        assign at_last = (phase == CW'(DIV - 1));

        // Count raw ticks modulo DIV, restarting on a reload.
        always_ff @(posedge clk) begin
            if (!rst_n)
                phase <= '0;
            else if (restart)
                phase <= '0;
            else if (raw_tick[g])
                phase <= at_last ? '0 : phase + 1'b1;
        end

        assign div_tick[g] = raw_tick[g] && at_last && !restart;
    end

    // Pick the tick that drives the countdown.
    always_comb begin
        case (src)
            SRC_FAST:     tick_out = raw_tick[0];
            SRC_FAST_DIV: tick_out = div_tick[0];
            SRC_SEC:      tick_out = raw_tick[1];
            SRC_SEC_DIV:  tick_out = div_tick[1];
            default:      tick_out = 1'b0;
        endcase
    end
endmodule

// File: rtl/sec_wdt_count.sv
// Countdown core: holds the byte count and the timeout flag. A load takes
// priority over a stop, which takes priority over a tick. Assumes at most
// one of load/stop per cycle. The count parks at zero after expiry.
module sec_wdt_count
    import sec_wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [REG_DW-1:0] load_val,
    input  logic              stop,
    input  logic              run,
    input  logic              tick,
    input  logic              flag_clr,
    output logic [REG_DW-1:0] value,
    output logic              flag,
    output logic              expire
);
    assign expire = run && tick && !load && !stop && (value == REG_DW'(1));

    // Reload, stop or decrement the count.
    always_ff @(posedge clk) begin
        if (!rst_n)
            value <= '0;
        else if (load)
            value <= load_val;
        else if (stop)
            value <= '0;
        else if (run && tick && (value != '0))
            value <= value - 1'b1;
    end

    // Timeout flag: a set wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (expire)
            flag <= 1'b1;
        else if (flag_clr)
            flag <= 1'b0;
    end
endmodule

// File: rtl/sec_wdt_rst_pulse.sv
// Reset pulse generator: on 'fire', holds the active-low output low for
// RST_CYCLES clocks. A new fire during a pulse restarts it. Assumes
// RST_CYCLES >= 1.
module sec_wdt_rst_pulse #(
    parameter int RST_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic pulse_n
);
    localparam int CW = ($clog2(RST_CYCLES) > 0) ? $clog2(RST_CYCLES) : 1;

    logic [CW-1:0] remain;
    logic          low_q;

    // Track the remaining low cycles of the pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
            low_q  <= 1'b0;
        end else if (fire) begin
            remain <= CW'(RST_CYCLES - 1);
            low_q  <= 1'b1;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end else begin
            low_q  <= 1'b0;
        end
    end

    assign pulse_n = !low_q;
endmodule

// File: rtl/sec_watchdog.sv
// Top: seconds-tick watchdog with register strobes. Holds the configuration
// register, decodes strobes into load/stop/clear and muxes read data.
// Assumes single-cycle strobes and that bus_rd and bus_wr are not both
// high in one cycle.
module sec_watchdog
    import sec_wdt_pkg::*;
#(
    parameter int TICK_DIV_FAST = 4,
    parameter int TICK_DIV_SLOW = 60,
    parameter int RST_CYCLES    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_fast,
    input  logic              tick_sec,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_DW-1:0] bus_wdata,
    output logic [REG_DW-1:0] bus_rdata,
    output logic              wd_flag,
    output logic              wd_rst_n
);
    wdt_cfg_t          cfg_q;
    logic [REG_DW-1:0] wd_value;
    logic              sel_tick;
    logic              expire;
    logic              do_load;
    logic              do_stop;
    logic              do_clr;

    assign do_load = bus_wr && (bus_addr == ADDR_VALUE);
    assign do_stop = bus_rd && (bus_addr == ADDR_STATUS);
    assign do_clr  = bus_wr && (bus_addr == ADDR_STATUS) && !bus_wdata[FLAG_BIT];

    // Configuration register write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= '{run: 1'b0, rst_en: 1'b0, src: SRC_FAST};
        else if (bus_wr && (bus_addr == ADDR_CFG))
            cfg_q <= '{run:    bus_wdata[CFG_RUN_BIT],
                       rst_en: bus_wdata[CFG_RSTEN_BIT],
                       src:    tick_src_e'(bus_wdata[1:0])};
    end

    sec_wdt_tick_sel #(
        .DIV_FAST (TICK_DIV_FAST),
        .DIV_SLOW (TICK_DIV_SLOW)
    ) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (do_load),
        .tick_fast (tick_fast),
        .tick_sec  (tick_sec),
        .src       (cfg_q.src),
        .tick_out  (sel_tick)
    );

    sec_wdt_count u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (do_load),
        .load_val (bus_wdata),
        .stop     (do_stop),
        .run      (cfg_q.run),
        .tick     (sel_tick),
        .flag_clr (do_clr),
        .value    (wd_value),
        .flag     (wd_flag),
        .expire   (expire)
    );

    sec_wdt_rst_pulse #(
        .RST_CYCLES (RST_CYCLES)
    ) u_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (expire && cfg_q.rst_en),
        .pulse_n (wd_rst_n)
    );

    // Read data mux for the addressed register.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_STATUS: bus_rdata[FLAG_BIT] = wd_flag;
            ADDR_CFG: begin
                bus_rdata[CFG_RUN_BIT]   = cfg_q.run;
                bus_rdata[CFG_RSTEN_BIT] = cfg_q.rst_en;
                bus_rdata[1:0]           = cfg_q.src;
            end
            ADDR_VALUE:  bus_rdata = wd_value;
            default:     bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/sec_watchdog_chk.sv
// Checker: temporal properties of the watchdog, bound to the top module.
module sec_watchdog_chk
    import sec_wdt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [REG_DW-1:0] bus_wdata,
    input logic [REG_DW-1:0] wd_value,
    input logic              sel_tick,
    input logic              cfg_run,
    input logic              cfg_rsten,
    input logic              wd_flag,
    input logic              wd_rst_n
);
    logic ld, st;
    assign ld = bus_wr && (bus_addr == ADDR_VALUE);
    assign st = bus_rd && (bus_addr == ADDR_STATUS);

    assert_kick_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (wd_value == $past(bus_wdata)));

    assert_idle_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_tick && !ld && !st) |=> $stable(wd_value));

    assert_park_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((wd_value == '0) && !ld) |=> (wd_value == '0));

    assert_expire_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_run && sel_tick && (wd_value == REG_DW'(1)) && !ld && !st) |=> wd_flag);

    assert_pulse_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wd_rst_n) |-> (wd_flag && $past(cfg_rsten)));

    assert_status_read_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st |=> (wd_value == '0));

    assert_flag_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == ADDR_STATUS) && !bus_wdata[FLAG_BIT] && (wd_value == '0))
        |=> !wd_flag);

    assert_hold_when_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_run && !ld && !st) |=> $stable(wd_value));
endmodule

bind sec_watchdog sec_watchdog_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .wd_value  (wd_value),
    .sel_tick  (sel_tick),
    .cfg_run   (cfg_q.run),
    .cfg_rsten (cfg_q.rst_en),
    .wd_flag   (wd_flag),
    .wd_rst_n  (wd_rst_n)
);

// File: tb/tb_sec_watchdog.sv
module tb_sec_watchdog;
    localparam int CLK_PERIOD = 10;
    localparam int DIV_FAST   = 4;
    localparam int DIV_SLOW   = 60;
    localparam int RST_CYC    = 16;
    localparam int WATCHDOG_CYCLES = 200000;

    localparam logic [1:0] A_ST  = 2'd0;
    localparam logic [1:0] A_CFG = 2'd1;
    localparam logic [1:0] A_VAL = 2'd2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_fast = 1'b0;
    logic       tick_sec = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       wd_flag;
    logic       wd_rst_n;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [7:0] exp;
        string      req;
    } exp_t;
    exp_t sbq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    sec_watchdog #(
        .TICK_DIV_FAST (DIV_FAST),
        .TICK_DIV_SLOW (DIV_SLOW),
        .RST_CYCLES    (RST_CYC)
    ) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_fast (tick_fast),
        .tick_sec  (tick_sec),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .wd_flag   (wd_flag),
        .wd_rst_n  (wd_rst_n)
    );

    // Monitor: pop expected read data and compare mid-cycle.
    always @(negedge clk) begin
        if (rst_n && bus_rd) begin
            n_chk++;
            if (sbq.size() == 0) begin
                n_fail++;
                $display("FAIL unexpected read: actual %02h expected none", bus_rdata);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                if (bus_rdata !== e.exp) begin
                    n_fail++;
                    $display("FAIL %s: read actual %02h expected %02h", e.req, bus_rdata, e.exp);
                end
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic rd_exp(input logic [1:0] a, input logic [7:0] e, input string req);
        exp_t item;
        item.exp = e;
        item.req = req;
        sbq.push_back(item);
        bus_rd = 1'b1; bus_addr = a;
        step();
        bus_rd = 1'b0;
    endtask

    task automatic pin_chk(input string req, input logic act, input logic e);
        n_chk++;
        if (act !== e) begin
            n_fail++;
            $display("FAIL %s: pin actual %0b expected %0b", req, act, e);
        end
    endtask

    task automatic ticks(input bit use_sec, input int n);
        for (int i = 0; i < n; i++) begin
            if (use_sec) tick_sec = 1'b1; else tick_fast = 1'b1;
            step();
            tick_sec = 1'b0; tick_fast = 1'b0;
            step();
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: bench did not finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int lows;
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R1: reset state
        pin_chk("R1 flag", wd_flag, 1'b0);
        pin_chk("R1 rst_n", wd_rst_n, 1'b1);
        rd_exp(A_VAL, 8'h00, "R1 value");
        rd_exp(A_CFG, 8'h00, "R1 cfg");
        rd_exp(A_ST, 8'h00, "R1 status");

        // R11: configuration readback
        wr(A_CFG, 8'hFF);
        rd_exp(A_CFG, 8'hC3, "R11 cfg readback");

        // R2/R9/R4/R5: one-second source with reset enabled
        wr(A_CFG, 8'hC2);
        wr(A_VAL, 8'd3);
        rd_exp(A_VAL, 8'd3, "R2 loaded");
        ticks(1, 2);
        rd_exp(A_VAL, 8'd1, "R2 countdown");
        ticks(0, 3);
        rd_exp(A_VAL, 8'd1, "R9 unselected source");
        tick_sec = 1'b1;
        step();
        tick_sec = 1'b0;
        pin_chk("R4 flag set", wd_flag, 1'b1);
        pin_chk("R5 pulse start", wd_rst_n, 1'b0);
        repeat (RST_CYC - 1) step();
        pin_chk("R5 pulse last cycle", wd_rst_n, 1'b0);
        step();
        pin_chk("R5 pulse end", wd_rst_n, 1'b1);
        rd_exp(A_VAL, 8'd0, "R4 parked");
        ticks(1, 2);
        rd_exp(A_VAL, 8'd0, "R4 no wrap");

        // R7: write 1 keeps flag, write 0 clears it
        wr(A_ST, 8'hFF);
        rd_exp(A_ST, 8'h40, "R7 write one keeps");
        wr(A_ST, 8'h00);
        rd_exp(A_ST, 8'h00, "R7 cleared");
        pin_chk("R7 flag pin", wd_flag, 1'b0);

        // R3: kick reloads
        wr(A_VAL, 8'd5);
        ticks(1, 3);
        rd_exp(A_VAL, 8'd2, "R3 before kick");
        wr(A_VAL, 8'd4);
        rd_exp(A_VAL, 8'd4, "R3 reloaded");
        ticks(1, 3);
        rd_exp(A_VAL, 8'd1, "R3 after kick");
        pin_chk("R3 no timeout", wd_flag, 1'b0);

        // R6: status read stops the timer
        rd_exp(A_ST, 8'h00, "R6 status read");
        rd_exp(A_VAL, 8'd0, "R6 value cleared");
        ticks(1, 5);
        rd_exp(A_VAL, 8'd0, "R6 stays stopped");
        pin_chk("R6 no flag", wd_flag, 1'b0);
        pin_chk("R6 no pulse", wd_rst_n, 1'b1);

        // R8: writing zero keeps it stopped
        wr(A_VAL, 8'd0);
        ticks(1, 3);
        rd_exp(A_VAL, 8'd0, "R8 zero stopped");
        pin_chk("R8 no flag", wd_flag, 1'b0);

        // R10: run bit clear holds the count
        wr(A_CFG, 8'h42);
        wr(A_VAL, 8'd2);
        ticks(1, 3);
        rd_exp(A_VAL, 8'd2, "R10 held");
        wr(A_CFG, 8'hC2);
        ticks(1, 1);
        rd_exp(A_VAL, 8'd1, "R10 resumes");
        rd_exp(A_ST, 8'h00, "R6 stop before next");

        // R5: reset output disabled
        wr(A_CFG, 8'h82);
        wr(A_VAL, 8'd1);
        tick_sec = 1'b1;
        step();
        tick_sec = 1'b0;
        pin_chk("R5 flag without reset", wd_flag, 1'b1);
        lows = 0;
        for (int i = 0; i < RST_CYC + 2; i++) begin
            if (wd_rst_n === 1'b0) lows++;
            step();
        end
        n_chk++;
        if (lows != 0) begin
            n_fail++;
            $display("FAIL R5 reset disabled: low cycles actual %0d expected 0", lows);
        end
        wr(A_ST, 8'h00);

        // R9: fast direct
        wr(A_CFG, 8'h80);
        wr(A_VAL, 8'd2);
        ticks(0, 1);
        rd_exp(A_VAL, 8'd1, "R9 fast direct");
        ticks(1, 2);
        rd_exp(A_VAL, 8'd1, "R9 second tick ignored");
        ticks(0, 1);
        pin_chk("R9 fast direct expiry", wd_flag, 1'b1);
        wr(A_ST, 8'h00);

        // R9: fast divided
        wr(A_CFG, 8'h81);
        wr(A_VAL, 8'd1);
        ticks(0, DIV_FAST - 1);
        rd_exp(A_VAL, 8'd1, "R9 fast divided early");
        pin_chk("R9 fast divided no flag", wd_flag, 1'b0);
        ticks(0, 1);
        pin_chk("R9 fast divided expiry", wd_flag, 1'b1);
        wr(A_ST, 8'h00);

        // R9: second divided
        wr(A_CFG, 8'h83);
        wr(A_VAL, 8'd1);
        ticks(1, DIV_SLOW - 1);
        rd_exp(A_VAL, 8'd1, "R9 slow divided early");
        ticks(1, 1);
        pin_chk("R9 slow divided expiry", wd_flag, 1'b1);
        wr(A_ST, 8'h00);

        // R7: timeout beats a simultaneous clear
        wr(A_CFG, 8'h82);
        wr(A_VAL, 8'd1);
        tick_sec = 1'b1;
        bus_wr = 1'b1; bus_addr = A_ST; bus_wdata = 8'h00;
        step();
        tick_sec = 1'b0; bus_wr = 1'b0;
        pin_chk("R7 set beats clear", wd_flag, 1'b1);
        rd_exp(A_ST, 8'h40, "R7 status after race");

        step();
        step();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule